// File: doc/BRIEF.md
# Three-Address Load/Store Core

A small multi-cycle processor that runs a fixed program from a synchronous instruction ROM and works on a synchronous data RAM. Both memories sit outside the block. Each instruction names one destination register (C) and two source registers (A and B). It does one of five things:

- writes a constant into C;
- loads a data word into C;
- stores register A to memory;
- adds A and B into C;
- multiplies A and B into C.

A halt instruction stops the core and raises a done flag.

Every instruction takes exactly three cycles: fetch, execute and writeback. In the fetch cycle the program counter addresses the ROM. In the execute cycle the returned word is decoded, the register file is read, and any load or store request goes out. In the writeback cycle the destination register is written and the program counter advances by one. Reset is asserted asynchronously. The reset controller must release it in step with the clock.

The instruction word is 32 bits, with these fields:

| Bits | Field |
|------|-------|
| [31:28] | opcode |
| [27:24] | destination C |
| [23:20] | source A |
| [19:16] | source B |
| [15:0] | immediate or data address |

Opcode values:

| Opcode | Meaning |
|--------|---------|
| 0 | halt |
| 1 | load immediate |
| 2 | load from memory |
| 3 | store |
| 4 | add |
| 5 | multiply |
| 6 to 15 | no operation |

Top module: `tac_core`

## Requirements
- R1: While reset is low and after its release, imem_addr is 0, done is 0, and neither memory enable is set. All 16 registers read as 0 until written; a store of a never-written register writes 0.
- R2: Instructions take three cycles each: fetch, execute, writeback. imem_addr holds the PC for the whole instruction and grows by exactly one after each writeback.
- R3: A load immediate (opcode 1) writes the 16-bit field [15:0], zero-extended to 32 bits, into register C.
- R4: A memory load (opcode 2) raises dmem_ld_en for exactly its execute cycle, with dmem_ld_addr equal to field [15:0]. The word the RAM returns one clock later is written into register C.
- R5: A store (opcode 3) raises dmem_st_en for exactly its execute cycle, with dmem_st_addr equal to field [15:0] and dmem_st_data equal to register A. The two memory enables are never high together.
- R6: An add (opcode 4) writes A + B modulo 2^32 into C.
- R7: A multiply (opcode 5) writes the low 32 bits of A × B into C. Source values are those from before the instruction, even when C equals A or B.
- R8: Only opcodes 1, 2, 4 and 5 write a register. A store and the unused opcodes 6 to 15 leave every register unchanged, whatever their C field holds.
- R9: A halt (opcode 0) sets done from the cycle after its execute cycle onward. The PC then stays frozen on the halt's address, and no later instruction makes a memory request.
- R10: The six-instruction sequence R0=Mem[100]; R1=Mem[101]; R2=#42; R2=R1*R2; R0=R2+R0; Mem[100]=R0 leaves Mem[100] equal to its old value plus 42 times Mem[101].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| imem_addr | output | PC_W (8) | Instruction ROM address (the program counter) |
| imem_data | input | 32 | ROM word, valid one clock after the address |
| dmem_ld_en | output | 1 | Data RAM read request |
| dmem_ld_addr | output | DA_W (16) | Data RAM read address |
| dmem_ld_data | input | DW (32) | Read word, valid one clock after the request |
| dmem_st_en | output | 1 | Data RAM write request |
| dmem_st_addr | output | DA_W (16) | Data RAM write address |
| dmem_st_data | output | DW (32) | Data RAM write word |
| done | output | 1 | Core has halted |

## Verification
Memory requests come out in the cycle after the fetch edge, which is the second cycle of an instruction. A loaded word or an ALU result reaches its register at the end of the third cycle. It therefore becomes visible through a later store's dmem_st_data three or more cycles afterwards. The bench runs a behavioural model that advances one step per clock and compares every output at each falling edge. Load and store fields are checked only in the cycles where the model expects a request. After each program, the RAM contents are also checked against hand-computed constants. done is expected one cycle after the halt's execute cycle, and the frozen PC and quiet enables are then checked for several further cycles.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 4;
  localparam int RF_AW  = 4;
  localparam int IMM_W  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_HALT = 4'd0,
    OP_LDI  = 4'd1,
    OP_LD   = 4'd2,
    OP_ST   = 4'd3,
    OP_ADD  = 4'd4,
    OP_MUL  = 4'd5
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_WB    = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;

  typedef struct packed {
    opcode_e          op;
    logic [RF_AW-1:0] dst;
    logic [IMM_W-1:0] imm;
  } wb_ctx_t;
endpackage

// File: rtl/tac_regfile.sv
module tac_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel;
    assign sel = we && (wa == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (sel) begin
        regs_q[g] <= wd;
      end
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];
endmodule

// File: rtl/tac_alu.sv
module tac_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          mul_sel,
  output logic [DW-1:0] y
);
  logic [DW-1:0] sum;
  logic [DW-1:0] prod;

  assign sum  = a + b;
  assign prod = a * b;
  assign y    = mul_sel ? prod : sum;
endmodule

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  opcode_e         exec_op,
  input  opcode_e         wb_op,
  output logic [PC_W-1:0] pc,
  output logic            in_exec,
  output logic            ld_en,
  output logic            st_en,
  output logic            rf_we,
  output logic            halted
);
  phase_e          phase_q, phase_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_adv;

  always_comb begin
    phase_d = phase_q;
    pc_adv  = 1'b0;
    unique case (phase_q)
      PH_FETCH: phase_d = PH_EXEC;
      PH_EXEC:  phase_d = (exec_op == OP_HALT) ? PH_HALT : PH_WB;
      PH_WB: begin
        phase_d = PH_FETCH;
        pc_adv  = 1'b1;
      end
      default:  phase_d = PH_HALT;
    endcase
    pc_d = pc_adv ? pc_q + PC_W'(1) : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (pc_adv) begin
        pc_q <= pc_d;
      end
    end
  end

  assign pc      = pc_q;
  assign in_exec = (phase_q == PH_EXEC);
  assign ld_en   = in_exec && (exec_op == OP_LD);
  assign st_en   = in_exec && (exec_op == OP_ST);
  assign halted  = (phase_q == PH_HALT);
  assign rf_we   = (phase_q == PH_WB) &&
                   (wb_op == OP_LDI || wb_op == OP_LD ||
                    wb_op == OP_ADD || wb_op == OP_MUL);
endmodule

// File: rtl/tac_core.sv
module tac_core
  import tac_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DW   = 32,
  parameter int DA_W = 16,
  localparam int NREG = 1 << RF_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PC_W-1:0]     imem_addr,
  input  logic [INSN_W-1:0]   imem_data,
  output logic                dmem_ld_en,
  output logic [DA_W-1:0]     dmem_ld_addr,
  input  logic [DW-1:0]       dmem_ld_data,
  output logic                dmem_st_en,
  output logic [DA_W-1:0]     dmem_st_addr,
  output logic [DW-1:0]       dmem_st_data,
  output logic                done
);
  // decode of the word returned by the ROM (meaningful in execute)
  opcode_e          ex_op;
  logic [RF_AW-1:0] ex_dst, ex_sa, ex_sb;
  logic [IMM_W-1:0] ex_imm;

  assign ex_op  = opcode_e'(imem_data[31:28]);
  assign ex_dst = imem_data[27:24];
  assign ex_sa  = imem_data[23:20];
  assign ex_sb  = imem_data[19:16];
  assign ex_imm = imem_data[15:0];

  logic          in_exec, rf_we;
  logic [DW-1:0] rd_a, rd_b, alu_y, wr_data;
  wb_ctx_t       wb_q, wb_d;
  logic [DW-1:0] res_q;

  tac_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_op (ex_op),
    .wb_op   (wb_q.op),
    .pc      (imem_addr),
    .in_exec (in_exec),
    .ld_en   (dmem_ld_en),
    .st_en   (dmem_st_en),
    .rf_we   (rf_we),
    .halted  (done)
  );

  tac_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_a  (ex_sa),
    .ra_b  (ex_sb),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .we    (rf_we),
    .wa    (wb_q.dst),
    .wd    (wr_data)
  );

  tac_alu #(.DW(DW)) alu_i (
    .a       (rd_a),
    .b       (rd_b),
    .mul_sel (ex_op == OP_MUL),
    .y       (alu_y)
  );

  assign wb_d = '{op: ex_op, dst: ex_dst, imm: ex_imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q  <= '{op: OP_HALT, dst: '0, imm: '0};
      res_q <= '0;
    end else if (in_exec) begin
      wb_q  <= wb_d;
      res_q <= alu_y;
    end
  end

  always_comb begin
    unique case (wb_q.op)
      OP_LDI:  wr_data = DW'(wb_q.imm);
      OP_LD:   wr_data = dmem_ld_data;
      default: wr_data = res_q;
    endcase
  end

  assign dmem_ld_addr = ex_imm[DA_W-1:0];
  assign dmem_st_addr = ex_imm[DA_W-1:0];
  assign dmem_st_data = rd_a;
endmodule

// File: rtl/tac_core_chk.sv
module tac_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] imem_addr,
  input logic            dmem_ld_en,
  input logic            dmem_st_en,
  input logic            done
);
  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_ld_en && dmem_st_en));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_addr != $past(imem_addr)) |-> (imem_addr == $past(imem_addr) + PC_W'(1)));

  // R4
  ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_ld_en |=> !dmem_ld_en);

  // R5
  st_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_st_en |=> !dmem_st_en);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(imem_addr)));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dmem_ld_en && !dmem_st_en));
endmodule

bind tac_core tac_core_chk #(.PC_W(PC_W)) chk_i (.*);

// File: tb/tac_core_tb_top.sv
module tac_core_tb_top;
  localparam int PC_W = 8;
  localparam int DW   = 32;
  localparam int DA_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_data;
  logic            dmem_ld_en, dmem_st_en, done;
  logic [DA_W-1:0] dmem_ld_addr, dmem_st_addr;
  logic [DW-1:0]   dmem_ld_data, dmem_st_data;

  always #2 clk = ~clk;

  tac_core #(.PC_W(PC_W), .DW(DW), .DA_W(DA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_ld_en(dmem_ld_en), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dmem_st_en(dmem_st_en), .dmem_st_addr(dmem_st_addr), .dmem_st_data(dmem_st_data),
    .done(done)
  );

  // synchronous memories
  logic [31:0] rom [256];
  logic [31:0] ram [256];
  logic [31:0] rom_q, ld_q;
  always @(posedge clk) begin
    rom_q <= rom[imem_addr];
    if (dmem_st_en) ram[dmem_st_addr[7:0]] <= dmem_st_data;
    if (dmem_ld_en) ld_q <= ram[dmem_ld_addr[7:0]];
  end
  assign imem_data    = rom_q;
  assign dmem_ld_data = ld_q;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int c, input int a, input int b, input int imm);
    return {4'(op), 4'(c), 4'(a), 4'(b), 16'(imm)};
  endfunction

  // behavioural reference model
  int          m_phase;  // 0 fetch, 1 exec, 2 wb, 3 halted
  logic [7:0]  m_pc;
  logic        m_done;
  logic [31:0] m_reg [16];
  logic [31:0] m_mem [256];
  logic [31:0] m_insn, m_ld;

  task automatic model_reset();
    m_phase = 0; m_pc = '0; m_done = 1'b0; m_insn = '0; m_ld = '0;
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
  endtask

  task automatic compare();
    logic [31:0] w;
    int op;
    logic exp_ld, exp_st;
    w  = rom[m_pc];
    op = int'(w[31:28]);
    exp_ld = (m_phase == 1) && (op == 2);
    exp_st = (m_phase == 1) && (op == 3);
    check("R2", 32'(imem_addr), 32'(m_pc));
    check("R9", 32'(done), 32'(m_done));
    check("R4", 32'(dmem_ld_en), 32'(exp_ld));
    check("R5", 32'(dmem_st_en), 32'(exp_st));
    if (exp_ld) check("R4", 32'(dmem_ld_addr), 32'(w[15:0]));
    if (exp_st) begin
      check("R5", 32'(dmem_st_addr), 32'(w[15:0]));
      check("R5", dmem_st_data, m_reg[w[23:20]]);
    end
  endtask

  task automatic advance();
    int op;
    case (m_phase)
      0: m_phase = 1;
      1: begin
        m_insn = rom[m_pc];
        op = int'(m_insn[31:28]);
        if (op == 0) begin
          m_phase = 3; m_done = 1'b1;
        end else begin
          if (op == 2) m_ld = m_mem[m_insn[7:0]];
          if (op == 3) m_mem[m_insn[7:0]] = m_reg[m_insn[23:20]];
          m_phase = 2;
        end
      end
      2: begin
        op = int'(m_insn[31:28]);
        case (op)
          1: m_reg[m_insn[27:24]] = {16'h0, m_insn[15:0]};
          2: m_reg[m_insn[27:24]] = m_ld;
          4: m_reg[m_insn[27:24]] = m_reg[m_insn[23:20]] + m_reg[m_insn[19:16]];
          5: m_reg[m_insn[27:24]] = m_reg[m_insn[23:20]] * m_reg[m_insn[19:16]];
          default: ;
        endcase
        m_pc = m_pc + 8'd1;
        m_phase = 0;
      end
      default: ;
    endcase
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      rom[i] = '0; ram[i] = '0; m_mem[i] = '0;
    end
  endtask

  task automatic set_mem(input int addr, input logic [31:0] v);
    ram[addr] = v; m_mem[addr] = v;
  endtask

  task automatic run_prog();
    int cyc = 0;
    int halt_cyc = 0;
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      // R1 reset state
      check("R1", 32'(imem_addr), 32'd0);
      check("R1", 32'(done), 32'd0);
      check("R1", 32'(dmem_ld_en), 32'd0);
      check("R1", 32'(dmem_st_en), 32'd0);
    end
    rst_n = 1'b1;
    while (halt_cyc < 6 && cyc < 600) begin
      compare();
      advance();
      if (m_done) halt_cyc++;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 600) check("R9", 32'(done), 32'd1);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Program B: reset contents, immediates, arithmetic wrap, non-writing ops, halt
    clear_mems();
    rom[0]  = enc(3, 4, 5, 0, 10);
    rom[1]  = enc(1, 3, 0, 0, 16'hFFFF);
    rom[2]  = enc(1, 4, 0, 0, 16'h8001);
    rom[3]  = enc(4, 6, 3, 4, 0);
    rom[4]  = enc(5, 7, 3, 3, 0);
    rom[5]  = enc(5, 9, 7, 3, 0);
    rom[6]  = enc(4, 10, 7, 7, 0);
    rom[7]  = enc(9, 3, 6, 6, 0);
    rom[8]  = enc(3, 4, 3, 0, 11);
    rom[9]  = enc(3, 0, 4, 0, 12);
    rom[10] = enc(3, 0, 6, 0, 13);
    rom[11] = enc(3, 0, 7, 0, 14);
    rom[12] = enc(3, 0, 9, 0, 15);
    rom[13] = enc(3, 0, 10, 0, 16);
    rom[14] = enc(2, 0, 0, 0, 16);
    rom[15] = enc(3, 0, 0, 0, 17);
    rom[16] = enc(0, 0, 0, 0, 0);
    rom[17] = enc(3, 0, 3, 0, 18);
    set_mem(10, 32'h5555_5555);
    set_mem(18, 32'h0000_DEAD);
    run_prog();
    check("R1", ram[10], 32'h0000_0000);
    check("R3", ram[11], 32'h0000_FFFF);   // R8: undefined opcode left R3 alone
    check("R8", ram[12], 32'h0000_8001);   // store's C field did not write R4
    check("R6", ram[13], 32'h0001_8000);
    check("R7", ram[14], 32'hFFFE_0001);
    check("R7", ram[15], 32'h0002_FFFF);
    check("R6", ram[16], 32'hFFFC_0002);
    check("R4", ram[17], 32'hFFFC_0002);
    check("R9", ram[18], 32'h0000_DEAD);

    // Program A: R10 sequence (reset also clears registers left by program B)
    clear_mems();
    rom[0] = enc(2, 0, 0, 0, 100);
    rom[1] = enc(2, 1, 0, 0, 101);
    rom[2] = enc(1, 2, 0, 0, 42);
    rom[3] = enc(5, 2, 1, 2, 0);
    rom[4] = enc(4, 0, 2, 0, 0);
    rom[5] = enc(3, 0, 0, 0, 100);
    rom[6] = enc(0, 0, 0, 0, 0);
    set_mem(100, 32'd1000);
    set_mem(101, 32'd7);
    run_prog();
    check("R10", ram[100], 32'd1294);
    check("R10", ram[101], 32'd7);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule